// File: doc/BRIEF.md
# ECC Memory Controller Register Bank

This block holds the software-visible control and status words of an ECC-protected memory controller. A simple 32-bit word bus reads and writes nine registers, selected by the word index in the address bits above bit 1. The registers cover memory enable, timing delay, fault status, slot configuration, two fault address words, a diagnostic word and two event counters. Reads are combinational from the current register state. Writes take effect at the next clock edge.

A static `VARIANT` parameter (0, 1 or 2) selects the implementation flavour. The variant decides which enable bits are writable and which identity value sits in the top nibble of the enable register. It also decides which enable bits survive a soft reset, and whether a separate four-byte diagnostic window exists. Fault status and both fault address words are loaded from a capture port that stands in for the error-detection logic. A capture can raise the fault interrupt, and software clears that interrupt by writing the fault status word.

The block has two resets. `por_n` is the power-on reset: it seeds the enable register with the variant identity and clears the diagnostic window. `rst_n` is the soft reset: the enable register keeps only the bits the variant retains, and the other registers return to their reset values.

Top module: `ecc_regbank`

## Requirements
- R1: Word indices map as follows: 0 enable, 1 delay, 2 fault status, 3 slot configuration, 4 fault address 0, 5 fault address 1, 6 diagnostic, 7 event count 0, 8 event count 1. Reads of indices 9 to 15 return zero, and bus writes to those indices change no register.
- R2: In variant 0, a bus write to the enable register stores the written data ANDed with 0x00000103, so bits 31:28 read back as zero.
- R3: In variants 1 and 2, a bus write to the enable register stores the written data ANDed with 0x00000BFF, ORed with the identity value (variant number << 28).
- R4: A bus write to the delay register stores the written value with bit 31 forced to zero.
- R5: A bus write to fault status stores the full written word, and `fault_irq` is low from the next cycle, provided no capture happens in the same cycle.
- R6: On soft reset, the enable register is ANDed with 0x00000100 in variant 0, and with 0xFF000BFC (bits 31:24, 11 and 9:2) in variants 1 and 2.
- R7: Power-on reset and soft reset both set delay to 0x00000020 and fault address 0 to 0x07C00000. They set fault status, slot configuration, fault address 1, diagnostic, both event counters and `fault_irq` to zero.
- R8: After power-on reset, the enable register reads the identity value: 0x00000000, 0x10000000 or 0x20000000 for variants 0, 1 and 2.
- R9: In variant 0, the diagnostic window holds four bytes. A byte write with `diag_wr` stores `diag_wdata` at index `diag_addr`, `diag_rdata` returns the addressed byte, and power-on reset clears all four bytes. In variants 1 and 2, `diag_rdata` is always zero and byte writes have no effect.
- R10: Fault address 0 and fault address 1 ignore bus writes and change only through a capture or a reset.
- R11: When `cap_valid` is high, fault status, fault address 0 and fault address 1 load `cap_status`, `cap_addr0` and `cap_addr1`. A capture with bit 3 set (uncorrectable) raises `fault_irq` in the next cycle. A capture with bit 0 set (correctable) raises it only when enable bit 1 is set. Otherwise the capture leaves `fault_irq` unchanged. A capture takes priority over a bus write to fault status in the same cycle.
- R12: Slot configuration, diagnostic, event count 0 and event count 1 store all 32 written bits, and each keeps its own value independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | Soft reset, active low, synchronous |
| bus_wr | input | 1 | Word write strobe |
| bus_addr | input | ADDR_W | Byte address; bits above bit 1 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| diag_wr | input | 1 | Diagnostic window byte write strobe |
| diag_addr | input | DIAG_AW | Diagnostic window byte index |
| diag_wdata | input | 8 | Diagnostic window write byte |
| diag_rdata | output | 8 | Diagnostic window read byte |
| cap_valid | input | 1 | Fault capture strobe |
| cap_status | input | 32 | Captured fault status |
| cap_addr0 | input | 32 | Captured fault address word 0 |
| cap_addr1 | input | 32 | Captured fault address word 1 |
| fault_irq | output | 1 | Fault interrupt |

## Verification
The bench builds three instances, with `VARIANT` set to 0, 1 and 2, driven from one shared bus. Every write pattern is therefore compared against all three masking and retention rules at once, and both the present and the absent diagnostic window are exercised. The default 6-bit address reaches every one of the 16 word slots, so the sweeps cover all mapped and unmapped indices. The capture sweep walks all 16 combinations of the low four status bits with the interrupt-enable bit both clear and set.

// File: rtl/ecc_regbank_pkg.sv
package ecc_regbank_pkg;

    localparam int WORD_W = 32;

    localparam int IDX_ENABLE  = 0;
    localparam int IDX_DELAY   = 1;
    localparam int IDX_FSTAT   = 2;
    localparam int IDX_SLOTCFG = 3;
    localparam int IDX_FADDR0  = 4;
    localparam int IDX_FADDR1  = 5;
    localparam int IDX_DIAG    = 6;
    localparam int IDX_EVCNT0  = 7;
    localparam int IDX_EVCNT1  = 8;

    localparam logic [WORD_W-1:0] DELAY_WMASK = 32'h7FFF_FFFF;
    localparam logic [WORD_W-1:0] DELAY_RST   = 32'h0000_0020;
    localparam logic [WORD_W-1:0] FADDR0_RST  = 32'h07C0_0000;

    localparam int FS_CE_BIT  = 0;
    localparam int FS_UE_BIT  = 3;
    localparam int EN_IRQ_BIT = 1;

    function automatic logic [WORD_W-1:0] ident_word(input int variant);
        logic [WORD_W-1:0] r;
        r = WORD_W'(variant) << 28;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] enable_wmask(input int variant);
        return (variant == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
    endfunction

    function automatic logic [WORD_W-1:0] enable_keep(input int variant);
        return (variant == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
    endfunction

endpackage

// File: rtl/ecc_enable_ctl.sv
module ecc_enable_ctl
    import ecc_regbank_pkg::*;
#(
    parameter int VARIANT = 0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] enable_q
);

    localparam logic [WORD_W-1:0] IDENT = ident_word(VARIANT);
    localparam logic [WORD_W-1:0] WMASK = enable_wmask(VARIANT);
    localparam logic [WORD_W-1:0] KEEP  = enable_keep(VARIANT);

    typedef struct packed {
        logic [WORD_W-1:0] value;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!por_n) begin
            st_d.value = IDENT & KEEP;
        end else if (!rst_n) begin
            st_d.value = st_q.value & KEEP;
        end else if (wr_en) begin
            st_d.value = IDENT | (wdata & WMASK);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign enable_q = st_q.value;

    AST_ENABLE_IDENT: assert property (@(posedge clk) disable iff (!por_n)
        st_q.value[WORD_W-1:WORD_W-4] == IDENT[WORD_W-1:WORD_W-4]); // R3

endmodule

// File: rtl/ecc_fault_ctl.sv
module ecc_fault_ctl
    import ecc_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              irq_en,
    input  logic              cap_valid,
    input  logic [WORD_W-1:0] cap_status,
    input  logic [WORD_W-1:0] cap_addr0,
    input  logic [WORD_W-1:0] cap_addr1,
    output logic [WORD_W-1:0] status_q,
    output logic [WORD_W-1:0] faddr0_q,
    output logic [WORD_W-1:0] faddr1_q,
    output logic              irq
);

    typedef struct packed {
        logic [WORD_W-1:0] status;
        logic [WORD_W-1:0] faddr0;
        logic [WORD_W-1:0] faddr1;
        logic              irq;
    } fault_state_t;

    fault_state_t st_d, st_q;
    logic         raise;

    always_comb begin
        raise = cap_status[FS_UE_BIT] | (cap_status[FS_CE_BIT] & irq_en);
        st_d  = st_q;
        if (!por_n || !rst_n) begin
            st_d.status = '0;
            st_d.faddr0 = FADDR0_RST;
            st_d.faddr1 = '0;
            st_d.irq    = 1'b0;
        end else if (cap_valid) begin
            st_d.status = cap_status;
            st_d.faddr0 = cap_addr0;
            st_d.faddr1 = cap_addr1;
            if (raise) begin
                st_d.irq = 1'b1;
            end
        end else if (stat_wr) begin
            st_d.status = wdata;
            st_d.irq    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign status_q = st_q.status;
    assign faddr0_q = st_q.faddr0;
    assign faddr1_q = st_q.faddr1;
    assign irq      = st_q.irq;

    AST_STATUS_WR_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (stat_wr && !cap_valid) |=> !st_q.irq); // R5

    AST_UE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (cap_valid && cap_status[FS_UE_BIT]) |=> st_q.irq); // R11

    AST_CE_GATED: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (cap_valid && !cap_status[FS_UE_BIT] && !irq_en && !st_q.irq) |=> !st_q.irq); // R11

    AST_FADDR_HOLD: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !cap_valid |=> ($stable(st_q.faddr0) && $stable(st_q.faddr1))); // R10

endmodule

// File: rtl/ecc_diag_window.sv
module ecc_diag_window #(
    parameter bit PRESENT    = 1'b1,
    parameter int DIAG_BYTES = 4,
    localparam int DIAG_AW   = $clog2(DIAG_BYTES)
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               wr,
    input  logic [DIAG_AW-1:0] addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata
);

    generate
        if (PRESENT) begin : g_window
            typedef struct packed {
                logic [DIAG_BYTES-1:0][7:0] bytes;
            } diag_state_t;

            diag_state_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (!por_n) begin
                    st_d.bytes = '0;
                end else if (wr) begin
                    st_d.bytes[addr] = wdata;
                end
            end

            always_ff @(posedge clk) begin
                st_q <= st_d;
            end

            assign rdata = st_q.bytes[addr];

            AST_DIAG_WRITE_SEEN: assert property (@(posedge clk) disable iff (!por_n)
                (wr && $stable(addr)) |=> (rdata == $past(wdata) || addr != $past(addr))); // R9
        end else begin : g_absent
            logic unused_diag;
            assign unused_diag = ^{clk, por_n, wr, addr, wdata};
            assign rdata       = 8'h00;
        end
    endgenerate

endmodule

// File: rtl/ecc_regbank.sv
module ecc_regbank
    import ecc_regbank_pkg::*;
#(
    parameter int VARIANT    = 0,
    parameter int ADDR_W     = 6,
    parameter int DIAG_BYTES = 4,
    localparam int IDX_W     = ADDR_W - 2,
    localparam int DIAG_AW   = $clog2(DIAG_BYTES)
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               diag_wr,
    input  logic [DIAG_AW-1:0] diag_addr,
    input  logic [7:0]         diag_wdata,
    output logic [7:0]         diag_rdata,
    input  logic               cap_valid,
    input  logic [31:0]        cap_status,
    input  logic [31:0]        cap_addr0,
    input  logic [31:0]        cap_addr1,
    output logic               fault_irq
);

    typedef struct packed {
        logic [WORD_W-1:0] delay;
        logic [WORD_W-1:0] slotcfg;
        logic [WORD_W-1:0] diagreg;
        logic [WORD_W-1:0] evcnt0;
        logic [WORD_W-1:0] evcnt1;
    } misc_state_t;

    misc_state_t st_d, st_q;

    logic [IDX_W-1:0]  idx;
    logic              unused_addr_lo;
    logic [WORD_W-1:0] enable_q;
    logic [WORD_W-1:0] status_q;
    logic [WORD_W-1:0] faddr0_q;
    logic [WORD_W-1:0] faddr1_q;

    assign idx            = bus_addr[ADDR_W-1:2];
    assign unused_addr_lo = ^bus_addr[1:0];

    ecc_enable_ctl #(
        .VARIANT (VARIANT)
    ) u_enable (
        .clk      (clk),
        .por_n    (por_n),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && idx == IDX_W'(IDX_ENABLE)),
        .wdata    (bus_wdata),
        .enable_q (enable_q)
    );

    ecc_fault_ctl u_fault (
        .clk        (clk),
        .por_n      (por_n),
        .rst_n      (rst_n),
        .stat_wr    (bus_wr && idx == IDX_W'(IDX_FSTAT)),
        .wdata      (bus_wdata),
        .irq_en     (enable_q[EN_IRQ_BIT]),
        .cap_valid  (cap_valid),
        .cap_status (cap_status),
        .cap_addr0  (cap_addr0),
        .cap_addr1  (cap_addr1),
        .status_q   (status_q),
        .faddr0_q   (faddr0_q),
        .faddr1_q   (faddr1_q),
        .irq        (fault_irq)
    );

    ecc_diag_window #(
        .PRESENT    (VARIANT == 0),
        .DIAG_BYTES (DIAG_BYTES)
    ) u_diag (
        .clk   (clk),
        .por_n (por_n),
        .wr    (diag_wr),
        .addr  (diag_addr),
        .wdata (diag_wdata),
        .rdata (diag_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (!por_n || !rst_n) begin
            st_d.delay   = DELAY_RST;
            st_d.slotcfg = '0;
            st_d.diagreg = '0;
            st_d.evcnt0  = '0;
            st_d.evcnt1  = '0;
        end else if (bus_wr) begin
            if (idx == IDX_W'(IDX_DELAY))   st_d.delay   = bus_wdata & DELAY_WMASK;
            if (idx == IDX_W'(IDX_SLOTCFG)) st_d.slotcfg = bus_wdata;
            if (idx == IDX_W'(IDX_DIAG))    st_d.diagreg = bus_wdata;
            if (idx == IDX_W'(IDX_EVCNT0))  st_d.evcnt0  = bus_wdata;
            if (idx == IDX_W'(IDX_EVCNT1))  st_d.evcnt1  = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (idx)
            IDX_W'(IDX_ENABLE):  bus_rdata = enable_q;
            IDX_W'(IDX_DELAY):   bus_rdata = st_q.delay;
            IDX_W'(IDX_FSTAT):   bus_rdata = status_q;
            IDX_W'(IDX_SLOTCFG): bus_rdata = st_q.slotcfg;
            IDX_W'(IDX_FADDR0):  bus_rdata = faddr0_q;
            IDX_W'(IDX_FADDR1):  bus_rdata = faddr1_q;
            IDX_W'(IDX_DIAG):    bus_rdata = st_q.diagreg;
            IDX_W'(IDX_EVCNT0):  bus_rdata = st_q.evcnt0;
            IDX_W'(IDX_EVCNT1):  bus_rdata = st_q.evcnt1;
            default:             bus_rdata = '0;
        endcase
    end

    AST_DELAY_MSB_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
        (idx == IDX_W'(IDX_DELAY)) |-> (bus_rdata[WORD_W-1] == 1'b0)); // R4

    AST_EVCNT1_OWN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (bus_wr && idx == IDX_W'(IDX_EVCNT0)) |=> $stable(st_q.evcnt1)); // R12

endmodule

// File: tb/ecc_regbank_bench.sv
`timescale 1ns/1ps
module ecc_regbank_bench;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        diag_wr = 1'b0;
    logic [1:0]  diag_addr = '0;
    logic [7:0]  diag_wdata = '0;
    logic        cap_valid = 1'b0;
    logic [31:0] cap_status = '0;
    logic [31:0] cap_addr0 = '0;
    logic [31:0] cap_addr1 = '0;

    logic [31:0] rd_v0, rd_v1, rd_v2;
    logic [7:0]  dr_v0, dr_v1, dr_v2;
    logic        irq_v0, irq_v1, irq_v2;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    ecc_regbank #(.VARIANT(0)) u_ecc_regbank (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_v0), .diag_wr(diag_wr), .diag_addr(diag_addr),
        .diag_wdata(diag_wdata), .diag_rdata(dr_v0), .cap_valid(cap_valid),
        .cap_status(cap_status), .cap_addr0(cap_addr0), .cap_addr1(cap_addr1),
        .fault_irq(irq_v0));

    ecc_regbank #(.VARIANT(1)) u_ecc_regbank_v1 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_v1), .diag_wr(diag_wr), .diag_addr(diag_addr),
        .diag_wdata(diag_wdata), .diag_rdata(dr_v1), .cap_valid(cap_valid),
        .cap_status(cap_status), .cap_addr0(cap_addr0), .cap_addr1(cap_addr1),
        .fault_irq(irq_v1));

    ecc_regbank #(.VARIANT(2)) u_ecc_regbank_v2 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_v2), .diag_wr(diag_wr), .diag_addr(diag_addr),
        .diag_wdata(diag_wdata), .diag_rdata(dr_v2), .cap_valid(cap_valid),
        .cap_status(cap_status), .cap_addr0(cap_addr0), .cap_addr1(cap_addr1),
        .fault_irq(irq_v2));

    function automatic logic [31:0] exp_en_wr(input int v, input logic [31:0] d);
        if (v == 0) return d & 32'h0000_0103;
        return (32'(v) << 28) | (d & 32'h0000_0BFF);
    endfunction

    function automatic logic [31:0] exp_keep(input int v);
        return (v == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = 6'(idx << 2);
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic read3(input int idx, output logic [31:0] r0, output logic [31:0] r1,
                         output logic [31:0] r2);
        bus_addr = 6'(idx << 2);
        #0.5;
        r0 = rd_v0;
        r1 = rd_v1;
        r2 = rd_v2;
    endtask

    task automatic pulse_soft_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic capture(input logic [31:0] s, input logic [31:0] a0, input logic [31:0] a1);
        @(negedge clk);
        cap_valid  = 1'b1;
        cap_status = s;
        cap_addr0  = a0;
        cap_addr1  = a1;
        @(negedge clk);
        cap_valid  = 1'b0;
    endtask

    function automatic logic [31:0] reset_val(input int v, input int idx);
        case (idx)
            0: return 32'(v) << 28;
            1: return 32'h0000_0020;
            4: return 32'h07C0_0000;
            default: return 32'h0;
        endcase
    endfunction

    initial begin
        logic [31:0] r0, r1, r2;
        logic [31:0] pat;
        logic [31:0] wv [16];

        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R7 R8: reset sweep over every word slot
        for (int i = 0; i < 16; i++) begin
            read3(i, r0, r1, r2);
            chk("R7", $sformatf("reset v0 idx%0d", i), r0, reset_val(0, i));
            chk("R8", $sformatf("reset v1 idx%0d", i), r1, reset_val(1, i));
            chk("R8", $sformatf("reset v2 idx%0d", i), r2, reset_val(2, i));
        end
        chk("R7", "reset irq", {29'h0, irq_v0, irq_v1, irq_v2}, 32'h0);
        for (int b = 0; b < 4; b++) begin
            diag_addr = 2'(b);
            #0.5;
            chk("R9", $sformatf("diag reset byte%0d", b), {24'h0, dr_v0}, 32'h0);
        end

        // R2 R3: enable write sweep, walking ones plus all ones
        for (int k = 0; k <= 32; k++) begin
            pat = (k == 32) ? 32'hFFFF_FFFF : (32'h1 << k);
            bus_write(0, pat);
            read3(0, r0, r1, r2);
            chk("R2", $sformatf("enable v0 pat %h", pat), r0, exp_en_wr(0, pat));
            chk("R3", $sformatf("enable v1 pat %h", pat), r1, exp_en_wr(1, pat));
            chk("R3", $sformatf("enable v2 pat %h", pat), r2, exp_en_wr(2, pat));
        end

        // R4: delay write sweep
        for (int k = 0; k <= 32; k++) begin
            pat = (k == 32) ? 32'hFFFF_FFFF : (32'h1 << k);
            bus_write(1, pat);
            read3(1, r0, r1, r2);
            chk("R4", $sformatf("delay pat %h", pat), r0, pat & 32'h7FFF_FFFF);
            chk("R4", $sformatf("delay v2 pat %h", pat), r2, pat & 32'h7FFF_FFFF);
        end

        // R1 R10 R12: write a distinct word to all 16 slots, then read all back
        for (int i = 0; i < 16; i++) begin
            wv[i] = 32'hC3A5_0000 ^ (32'(i) * 32'h0101_0111);
            bus_write(i, wv[i]);
        end
        for (int i = 0; i < 16; i++) begin
            read3(i, r0, r1, r2);
            case (i)
                0: begin
                    chk("R2", "map enable v0", r0, exp_en_wr(0, wv[0]));
                    chk("R3", "map enable v1", r1, exp_en_wr(1, wv[0]));
                end
                1: chk("R4", "map delay", r0, wv[1] & 32'h7FFF_FFFF);
                2: chk("R5", "map status", r1, wv[2]);
                4: chk("R10", "map faddr0 ignores write", r0, 32'h07C0_0000);
                5: chk("R10", "map faddr1 ignores write", r2, 32'h0);
                3, 6, 7, 8: chk("R12", $sformatf("map full idx%0d", i), r1, wv[i]);
                default: chk("R1", $sformatf("map unmapped idx%0d", i), r0 | r1 | r2, 32'h0);
            endcase
        end

        // R6 R7: soft reset retention and reset values
        bus_write(0, 32'hFFFF_FFFF);
        pulse_soft_reset();
        read3(0, r0, r1, r2);
        chk("R6", "keep v0", r0, exp_en_wr(0, 32'hFFFF_FFFF) & exp_keep(0));
        chk("R6", "keep v1", r1, exp_en_wr(1, 32'hFFFF_FFFF) & exp_keep(1));
        chk("R6", "keep v2", r2, exp_en_wr(2, 32'hFFFF_FFFF) & exp_keep(2));
        for (int i = 1; i < 16; i++) begin
            read3(i, r0, r1, r2);
            chk("R7", $sformatf("soft reset idx%0d", i), r1, reset_val(1, i));
        end
        // mapped-bit subset also survives a second soft reset unchanged
        bus_write(0, 32'h0000_0A5C);
        pulse_soft_reset();
        read3(0, r0, r1, r2);
        chk("R6", "keep v0 pattern", r0, exp_en_wr(0, 32'h0000_0A5C) & exp_keep(0));
        chk("R6", "keep v2 pattern", r2, exp_en_wr(2, 32'h0000_0A5C) & exp_keep(2));

        // R11 R5: capture sweep over the low status bits with irq enable clear and set
        for (int ei = 0; ei < 2; ei++) begin
            bus_write(0, ei ? 32'h2 : 32'h0);
            for (int s = 0; s < 16; s++) begin
                bus_write(2, 32'h0);
                chk("R5", "irq cleared before capture", {29'h0, irq_v0, irq_v1, irq_v2}, 32'h0);
                capture(32'h0003_AB00 | 32'(s), 32'h0000_1000 + 32'(s), ~32'(s));
                pat = ((s & 8) != 0 || ((s & 1) != 0 && ei == 1)) ? 32'h7 : 32'h0;
                chk("R11", $sformatf("irq ei=%0d s=%0d", ei, s),
                    {29'h0, irq_v0, irq_v1, irq_v2}, pat);
                read3(2, r0, r1, r2);
                chk("R11", "captured status", r1, 32'h0003_AB00 | 32'(s));
                read3(4, r0, r1, r2);
                chk("R11", "captured faddr0", r0, 32'h0000_1000 + 32'(s));
                read3(5, r0, r1, r2);
                chk("R11", "captured faddr1", r2, ~32'(s));
            end
        end

        // R11: capture wins over a same-cycle status write
        bus_write(2, 32'h0);
        @(negedge clk);
        cap_valid = 1'b1; cap_status = 32'h0000_0008; cap_addr0 = 32'h55; cap_addr1 = 32'h66;
        bus_wr = 1'b1; bus_addr = 6'(2 << 2); bus_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        cap_valid = 1'b0; bus_wr = 1'b0;
        read3(2, r0, r1, r2);
        chk("R11", "capture priority status", r0, 32'h0000_0008);
        chk("R11", "capture priority irq", {31'h0, irq_v0}, 32'h1);
        // R5: status write alone stores and drops irq
        bus_write(2, 32'h1234_5678);
        read3(2, r0, r1, r2);
        chk("R5", "status write value", r2, 32'h1234_5678);
        chk("R5", "status write drops irq", {29'h0, irq_v0, irq_v1, irq_v2}, 32'h0);

        // R9: diagnostic window sweep
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            diag_wr = 1'b1; diag_addr = 2'(b); diag_wdata = 8'h3C + 8'(b * 37);
            @(negedge clk);
            diag_wr = 1'b0;
        end
        for (int b = 0; b < 4; b++) begin
            diag_addr = 2'(b);
            #0.5;
            chk("R9", $sformatf("diag v0 byte%0d", b), {24'h0, dr_v0}, 32'(8'h3C + 8'(b * 37)));
            chk("R9", $sformatf("diag absent byte%0d", b), {16'h0, dr_v1, dr_v2}, 32'h0);
        end
        @(negedge clk);
        diag_wr = 1'b1; diag_addr = 2'd2; diag_wdata = 8'hE1;
        @(negedge clk);
        diag_wr = 1'b0;
        for (int b = 0; b < 4; b++) begin
            diag_addr = 2'(b);
            #0.5;
            chk("R9", $sformatf("diag overwrite byte%0d", b), {24'h0, dr_v0},
                (b == 2) ? 32'hE1 : 32'(8'h3C + 8'(b * 37)));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule